// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block holds a small set of error-reporting banks and a pair of global machine-check registers, and it decides what to do with each hardware error report that is injected into it. Every bank keeps a control mask, a status word, an address word and a miscellaneous word. The global side has a read-only capability word, a global control mask and a global status word. The capability word comes from a parameter. Its low byte gives the number of usable banks, and one bit in it says that the global control mask is in force.

An injection request carries a bank index, a status word, an address, a miscellaneous word, a replacement global status word and a flag that forces delivery. The block first checks that the request is well formed. It then sorts the report by two status bits: whether the error was corrected or uncorrected, and whether software must act on it. From there it either logs the report, drops it, marks the bank as overflowed, raises a one-cycle machine-check interrupt or raises a one-cycle shutdown request. A separate configuration write port lets the surrounding logic set the control masks and clear status words between reports.

Every request is resolved in a single clock. The updated registers and the accept, reject, interrupt and shutdown pulses all appear together, one cycle after the request is presented.

Top module: `mcb_logger`

## Requirements
- R1: Under reset every bank register, the global control word, the global status word and all four pulse outputs are zero. The capability output equals the CAP_INIT parameter.
- R2: A request is rejected with no change of state if any of these holds: the capability word is zero, the bank index is not below the capability's low byte, the bank index is not below NUM_BANKS, or status bit 63 (valid) is 0. The reject output pulses for one cycle. Any other request pulses the accept output instead.
- R3: A report is dropped with no change of state in this case: global status bit 2 (in progress) is set, status bit 55 (action required) is 0, and the force flag is 0.
- R4: An uncorrected report (status bit 61 set) is dropped when capability bit 8 is set and the global control word is not all ones.
- R5: An uncorrected report that gets past R4 is dropped when the target bank's control word is not all ones.
- R6: An uncorrected report that gets past R5 leaves all registers unchanged and pulses the shutdown output if global status bit 2 is set or the cr4_mce_i input is 0.
- R7: Any other uncorrected report writes the bank's address and miscellaneous words, writes the bank status with bit 62 (overflow) added if the bank already held a valid entry, loads the global status from the request, and pulses the interrupt output.
- R8: A corrected report overwrites the bank when the bank's valid bit is 0 or its uncorrected bit is 0. It adds bit 62 when the old entry was valid. Against a valid uncorrected entry, the report only sets bit 62 of the bank status.
- R9: A configuration write is applied only in a cycle with no injection, and only if the bank index (for bank targets) is below NUM_BANKS. The target codes are: 0 bank control, 1 global control, 2 global status, 3 bank status.
- R10: The accept, reject, interrupt and shutdown outputs are one-cycle results of the request one cycle earlier. Accept and reject never rise together, and interrupt and shutdown never rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr4_mce_i | input | 1 | Machine-check delivery enabled by the processor |
| inj_valid_i | input | 1 | Injection request present |
| inj_bank_i | input | 8 | Target bank index |
| inj_status_i | input | 64 | Reported status word |
| inj_addr_i | input | 64 | Reported address word |
| inj_misc_i | input | 64 | Reported miscellaneous word |
| inj_mcg_status_i | input | 64 | Global status to load on an interrupt |
| inj_uncond_i | input | 1 | Deliver even while a check is in progress |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_target_i | input | 2 | Configuration target code |
| cfg_bank_i | input | 8 | Bank index for bank targets |
| cfg_data_i | input | 64 | Configuration write data |
| bank_ctl_o | output | NUM_BANKS*64 | All bank control words, bank 0 lowest |
| bank_status_o | output | NUM_BANKS*64 | All bank status words |
| bank_addr_o | output | NUM_BANKS*64 | All bank address words |
| bank_misc_o | output | NUM_BANKS*64 | All bank miscellaneous words |
| mcg_cap_o | output | 64 | Capability word |
| mcg_ctl_o | output | 64 | Global control word |
| mcg_status_o | output | 64 | Global status word |
| inj_accept_o | output | 1 | Request passed validation |
| inj_reject_o | output | 1 | Request failed validation |
| mce_irq_o | output | 1 | Machine-check interrupt pulse |
| shutdown_req_o | output | 1 | Shutdown request pulse |

## Verification
The main instance is built with four banks and a capability word of 0x104. This makes bank indices 4 and above invalid and puts the global control mask in force, so the range rejects and the R4 mask drop can both be reached. A second instance is built with a capability word of zero, which exercises the rule that rejects every request. One bank's control word is left at zero on purpose so that the per-bank drop can be reached. The interrupt sets the in-progress bit, which then brings the busy-drop and escalation paths within reach without a new reset.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int WORD_W  = 64;
  localparam int ST_VAL  = 63;
  localparam int ST_OVR  = 62;
  localparam int ST_UNC  = 61;
  localparam int ST_ACT  = 55;
  localparam int GS_BUSY = 2;
  localparam int CAP_GCP = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OC_REJECT    = 3'd0,
    OC_DROP_BUSY = 3'd1,
    OC_DROP_GCTL = 3'd2,
    OC_DROP_BCTL = 3'd3,
    OC_ESCALATE  = 3'd4,
    OC_LOG_UC    = 3'd5,
    OC_LOG_CE    = 3'd6,
    OC_MARK_OVR  = 3'd7
  } outcome_e;

  typedef enum logic [1:0] {
    CT_BANK_CTL   = 2'd0,
    CT_GLOB_CTL   = 2'd1,
    CT_GLOB_STS   = 2'd2,
    CT_BANK_STS   = 2'd3
  } cfg_target_e;
endpackage

// File: rtl/mcb_req_check.sv
module mcb_req_check #(
  parameter int NUM_BANKS = 4,
  parameter int SEL_W     = 2
) (
  input  logic [7:0]       cap_count_i,
  input  logic [7:0]       bank_i,
  input  logic             status_val_i,
  output logic             req_ok_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [7:0] NB8 = 8'(NUM_BANKS);

  logic cap_ok, range_ok;

  always_comb begin
    cap_ok   = (cap_count_i != 8'd0);
    range_ok = (bank_i < cap_count_i) && (bank_i < NB8);
    req_ok_o = cap_ok && range_ok && status_val_i;
    sel_o    = bank_i[SEL_W-1:0];
  end
endmodule

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
(
  input  logic     req_ok_i,
  input  word_t    inj_status_i,
  input  logic     uncond_i,
  input  logic     cap_gcp_i,
  input  word_t    glob_ctl_i,
  input  logic     glob_busy_i,
  input  logic     cr4_mce_i,
  input  word_t    bank_ctl_i,
  input  logic     bank_val_i,
  input  logic     bank_unc_i,
  output outcome_e outcome_o,
  output word_t    log_status_o
);
  logic ao_blocked, is_unc;

  always_comb begin
    ao_blocked   = glob_busy_i && !inj_status_i[ST_ACT] && !uncond_i;
    is_unc       = inj_status_i[ST_UNC];
    log_status_o = inj_status_i;
    if (bank_val_i) log_status_o[ST_OVR] = 1'b1;

    if (!req_ok_i) begin
      outcome_o = OC_REJECT;
    end else if (ao_blocked) begin
      outcome_o = OC_DROP_BUSY;
    end else if (is_unc) begin
      if (cap_gcp_i && (glob_ctl_i != '1)) begin
        outcome_o = OC_DROP_GCTL;
      end else if (bank_ctl_i != '1) begin
        outcome_o = OC_DROP_BCTL;
      end else if (glob_busy_i || !cr4_mce_i) begin
        outcome_o = OC_ESCALATE;
      end else begin
        outcome_o = OC_LOG_UC;
      end
    end else if (!bank_val_i || !bank_unc_i) begin
      outcome_o = OC_LOG_CE;
    end else begin
      outcome_o = OC_MARK_OVR;
    end
  end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
  import mcb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  log_en_i,
  input  word_t log_status_i,
  input  word_t log_addr_i,
  input  word_t log_misc_i,
  input  logic  ovr_en_i,
  input  logic  ctl_we_i,
  input  logic  sts_we_i,
  input  word_t cfg_data_i,
  output word_t ctl_q_o,
  output word_t status_q_o,
  output word_t addr_q_o,
  output word_t misc_q_o
);
  word_t ctl_q, sts_q, adr_q, msc_q;
  word_t ctl_d, sts_d, adr_d, msc_d;

  always_comb begin
    ctl_d = ctl_q;
    sts_d = sts_q;
    adr_d = adr_q;
    msc_d = msc_q;
    if (log_en_i) begin
      sts_d = log_status_i;
      adr_d = log_addr_i;
      msc_d = log_misc_i;
    end else if (ovr_en_i) begin
      sts_d[ST_OVR] = 1'b1;
    end else if (sts_we_i) begin
      sts_d = cfg_data_i;
    end
    if (ctl_we_i) ctl_d = cfg_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sts_q <= '0;
      adr_q <= '0;
      msc_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      sts_q <= sts_d;
      adr_q <= adr_d;
      msc_q <= msc_d;
    end
  end

  assign ctl_q_o    = ctl_q;
  assign status_q_o = sts_q;
  assign addr_q_o   = adr_q;
  assign misc_q_o   = msc_q;
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter logic [63:0] CAP_INIT  = 64'h0000_0000_0000_0104
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cr4_mce_i,
  input  logic                    inj_valid_i,
  input  logic [7:0]              inj_bank_i,
  input  logic [63:0]             inj_status_i,
  input  logic [63:0]             inj_addr_i,
  input  logic [63:0]             inj_misc_i,
  input  logic [63:0]             inj_mcg_status_i,
  input  logic                    inj_uncond_i,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_target_i,
  input  logic [7:0]              cfg_bank_i,
  input  logic [63:0]             cfg_data_i,
  output logic [NUM_BANKS*64-1:0] bank_ctl_o,
  output logic [NUM_BANKS*64-1:0] bank_status_o,
  output logic [NUM_BANKS*64-1:0] bank_addr_o,
  output logic [NUM_BANKS*64-1:0] bank_misc_o,
  output logic [63:0]             mcg_cap_o,
  output logic [63:0]             mcg_ctl_o,
  output logic [63:0]             mcg_status_o,
  output logic                    inj_accept_o,
  output logic                    inj_reject_o,
  output logic                    mce_irq_o,
  output logic                    shutdown_req_o
);
  localparam int         SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [7:0] NB8   = 8'(NUM_BANKS);

  word_t ctl_arr [NUM_BANKS];
  word_t sts_arr [NUM_BANKS];

  logic             req_ok;
  logic [SEL_W-1:0] sel;
  outcome_e         outcome;
  word_t            log_status;
  word_t            cur_ctl, cur_sts;

  word_t gctl_q, gctl_d, gsts_q, gsts_d;
  logic  acc_q, acc_d, rej_q, rej_d, irq_q, irq_d, shd_q, shd_d;

  cfg_target_e      cfg_tgt;
  logic             cfg_go, cfg_bank_ok;
  logic [SEL_W-1:0] cfg_sel;

  assign cfg_tgt     = cfg_target_e'(cfg_target_i);
  assign cfg_go      = cfg_we_i && !inj_valid_i;
  assign cfg_bank_ok = (cfg_bank_i < NB8);
  assign cfg_sel     = cfg_bank_i[SEL_W-1:0];

  mcb_req_check #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_check (
    .cap_count_i  (CAP_INIT[7:0]),
    .bank_i       (inj_bank_i),
    .status_val_i (inj_status_i[ST_VAL]),
    .req_ok_o     (req_ok),
    .sel_o        (sel)
  );

  assign cur_ctl = ctl_arr[sel];
  assign cur_sts = sts_arr[sel];

  mcb_decide u_decide (
    .req_ok_i     (req_ok),
    .inj_status_i (inj_status_i),
    .uncond_i     (inj_uncond_i),
    .cap_gcp_i    (CAP_INIT[CAP_GCP]),
    .glob_ctl_i   (gctl_q),
    .glob_busy_i  (gsts_q[GS_BUSY]),
    .cr4_mce_i    (cr4_mce_i),
    .bank_ctl_i   (cur_ctl),
    .bank_val_i   (cur_sts[ST_VAL]),
    .bank_unc_i   (cur_sts[ST_UNC]),
    .outcome_o    (outcome),
    .log_status_o (log_status)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic  hit, cfg_hit, log_en, ovr_en;
    word_t addr_q, misc_q;

    assign hit     = inj_valid_i && (sel == SEL_W'(i));
    assign cfg_hit = cfg_go && cfg_bank_ok && (cfg_sel == SEL_W'(i));
    assign log_en  = hit && ((outcome == OC_LOG_UC) || (outcome == OC_LOG_CE));
    assign ovr_en  = hit && (outcome == OC_MARK_OVR);

    mcb_bank u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .log_en_i     (log_en),
      .log_status_i (log_status),
      .log_addr_i   (inj_addr_i),
      .log_misc_i   (inj_misc_i),
      .ovr_en_i     (ovr_en),
      .ctl_we_i     (cfg_hit && (cfg_tgt == CT_BANK_CTL)),
      .sts_we_i     (cfg_hit && (cfg_tgt == CT_BANK_STS)),
      .cfg_data_i   (cfg_data_i),
      .ctl_q_o      (ctl_arr[i]),
      .status_q_o   (sts_arr[i]),
      .addr_q_o     (addr_q),
      .misc_q_o     (misc_q)
    );

    assign bank_ctl_o[i*64 +: 64]    = ctl_arr[i];
    assign bank_status_o[i*64 +: 64] = sts_arr[i];
    assign bank_addr_o[i*64 +: 64]   = addr_q;
    assign bank_misc_o[i*64 +: 64]   = misc_q;
  end

  always_comb begin
    gctl_d = gctl_q;
    gsts_d = gsts_q;
    acc_d  = inj_valid_i && (outcome != OC_REJECT);
    rej_d  = inj_valid_i && (outcome == OC_REJECT);
    irq_d  = inj_valid_i && (outcome == OC_LOG_UC);
    shd_d  = inj_valid_i && (outcome == OC_ESCALATE);
    if (irq_d) begin
      gsts_d = inj_mcg_status_i;
    end else if (cfg_go && (cfg_tgt == CT_GLOB_STS)) begin
      gsts_d = cfg_data_i;
    end
    if (cfg_go && (cfg_tgt == CT_GLOB_CTL)) gctl_d = cfg_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q <= '0;
      gsts_q <= '0;
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      irq_q  <= 1'b0;
      shd_q  <= 1'b0;
    end else begin
      gctl_q <= gctl_d;
      gsts_q <= gsts_d;
      acc_q  <= acc_d;
      rej_q  <= rej_d;
      irq_q  <= irq_d;
      shd_q  <= shd_d;
    end
  end

  assign mcg_cap_o      = CAP_INIT;
  assign mcg_ctl_o      = gctl_q;
  assign mcg_status_o   = gsts_q;
  assign inj_accept_o   = acc_q;
  assign inj_reject_o   = rej_q;
  assign mce_irq_o      = irq_q;
  assign shutdown_req_o = shd_q;
endmodule

// File: rtl/mcb_logger_chk.sv
module mcb_logger_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cr4_mce_i,
  input logic                    inj_valid_i,
  input logic [63:0]             inj_mcg_status_i,
  input logic [NUM_BANKS*64-1:0] bank_status_o,
  input logic [63:0]             mcg_status_o,
  input logic                    inj_accept_o,
  input logic                    inj_reject_o,
  input logic                    mce_irq_o,
  input logic                    shutdown_req_o
);
  a_r10_acc_rej_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(inj_accept_o && inj_reject_o));

  a_r10_irq_shd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mce_irq_o && shutdown_req_o));

  a_r10_result_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_accept_o || inj_reject_o) |-> $past(inj_valid_i));

  a_r2_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    inj_reject_o |-> ($stable(bank_status_o) && $stable(mcg_status_o)));

  a_r6_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req_o |-> ($past(!cr4_mce_i) || $past(mcg_status_o[2])));

  a_r6_shutdown_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req_o |-> ($stable(bank_status_o) && $stable(mcg_status_o)));

  a_r7_irq_loads_global: assert property (@(posedge clk) disable iff (!rst_n)
    mce_irq_o |-> (mcg_status_o == $past(inj_mcg_status_i)));
endmodule

bind mcb_logger mcb_logger_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cr4_mce_i        (cr4_mce_i),
  .inj_valid_i      (inj_valid_i),
  .inj_mcg_status_i (inj_mcg_status_i),
  .bank_status_o    (bank_status_o),
  .mcg_status_o     (mcg_status_o),
  .inj_accept_o     (inj_accept_o),
  .inj_reject_o     (inj_reject_o),
  .mce_irq_o        (mce_irq_o),
  .shutdown_req_o   (shutdown_req_o)
);

// File: tb/tb_mcb_logger.sv
module tb_mcb_logger;
  localparam int          NB  = 4;
  localparam logic [63:0] CAP = 64'h0000_0000_0000_0104;
  localparam logic [63:0] VAL = 64'h1 << 63;
  localparam logic [63:0] OVR = 64'h1 << 62;
  localparam logic [63:0] UNC = 64'h1 << 61;
  localparam logic [63:0] ACT = 64'h1 << 55;
  localparam logic [63:0] BSY = 64'h4;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic cr4;
  logic iv;
  logic [7:0] ib;
  logic [63:0] ist, iad, imi, igs;
  logic iun;
  logic cwe;
  logic [1:0] ctg;
  logic [7:0] cbk;
  logic [63:0] cdt;

  logic [NB*64-1:0] o_ctl, o_sts, o_adr, o_msc;
  logic [63:0] o_cap, o_gctl, o_gsts;
  logic o_acc, o_rej, o_irq, o_shd;

  logic [NB*64-1:0] z_ctl, z_sts, z_adr, z_msc;
  logic [63:0] z_cap, z_gctl, z_gsts;
  logic z_acc, z_rej, z_irq, z_shd;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mcb_logger #(.NUM_BANKS(NB), .CAP_INIT(CAP)) dut (
    .clk(clk), .rst_n(rst_n), .cr4_mce_i(cr4), .inj_valid_i(iv), .inj_bank_i(ib),
    .inj_status_i(ist), .inj_addr_i(iad), .inj_misc_i(imi), .inj_mcg_status_i(igs),
    .inj_uncond_i(iun), .cfg_we_i(cwe), .cfg_target_i(ctg), .cfg_bank_i(cbk),
    .cfg_data_i(cdt), .bank_ctl_o(o_ctl), .bank_status_o(o_sts), .bank_addr_o(o_adr),
    .bank_misc_o(o_msc), .mcg_cap_o(o_cap), .mcg_ctl_o(o_gctl), .mcg_status_o(o_gsts),
    .inj_accept_o(o_acc), .inj_reject_o(o_rej), .mce_irq_o(o_irq), .shutdown_req_o(o_shd));

  mcb_logger #(.NUM_BANKS(NB), .CAP_INIT(64'h0)) dut_nocap (
    .clk(clk), .rst_n(rst_n), .cr4_mce_i(cr4), .inj_valid_i(iv), .inj_bank_i(ib),
    .inj_status_i(ist), .inj_addr_i(iad), .inj_misc_i(imi), .inj_mcg_status_i(igs),
    .inj_uncond_i(iun), .cfg_we_i(cwe), .cfg_target_i(ctg), .cfg_bank_i(cbk),
    .cfg_data_i(cdt), .bank_ctl_o(z_ctl), .bank_status_o(z_sts), .bank_addr_o(z_adr),
    .bank_misc_o(z_msc), .mcg_cap_o(z_cap), .mcg_ctl_o(z_gctl), .mcg_status_o(z_gsts),
    .inj_accept_o(z_acc), .inj_reject_o(z_rej), .mce_irq_o(z_irq), .shutdown_req_o(z_shd));

  // Reference model, written from the requirements
  logic [63:0] m_ctl [NB];
  logic [63:0] m_sts [NB];
  logic [63:0] m_adr [NB];
  logic [63:0] m_msc [NB];
  logic [63:0] m_gctl, m_gsts;
  logic m_acc, m_rej, m_irq, m_shd, m_zrej, m_zacc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NB; k++) begin
        m_ctl[k] = '0; m_sts[k] = '0; m_adr[k] = '0; m_msc[k] = '0;
      end
      m_gctl = '0; m_gsts = '0;
      m_acc = 0; m_rej = 0; m_irq = 0; m_shd = 0; m_zrej = 0; m_zacc = 0;
    end else begin
      m_acc = 0; m_rej = 0; m_irq = 0; m_shd = 0;
      m_zrej = iv; m_zacc = 0;
      if (iv) begin
        int b;
        b = ib;
        if (CAP == 0 || b >= CAP[7:0] || b >= NB || !ist[63]) begin
          m_rej = 1;
        end else begin
          m_acc = 1;
          if (m_gsts[2] && !ist[55] && !iun) begin
            // busy drop
          end else if (ist[61]) begin
            if (CAP[8] && m_gctl != ONES) begin
            end else if (m_ctl[b] != ONES) begin
            end else if (m_gsts[2] || !cr4) begin
              m_shd = 1;
            end else begin
              m_sts[b] = m_sts[b][63] ? (ist | OVR) : ist;
              m_adr[b] = iad; m_msc[b] = imi; m_gsts = igs; m_irq = 1;
            end
          end else if (!m_sts[b][63] || !m_sts[b][61]) begin
            m_sts[b] = m_sts[b][63] ? (ist | OVR) : ist;
            m_adr[b] = iad; m_msc[b] = imi;
          end else begin
            m_sts[b] = m_sts[b] | OVR;
          end
        end
      end else if (cwe) begin
        case (ctg)
          2'd0: if (cbk < NB) m_ctl[cbk] = cdt;
          2'd1: m_gctl = cdt;
          2'd2: m_gsts = cdt;
          default: if (cbk < NB) m_sts[cbk] = cdt;
        endcase
      end
    end
  end

  task automatic cmp(string what, logic [NB*64-1:0] got, logic [NB*64-1:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %h exp %h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic [NB*64-1:0] e_ctl, e_sts, e_adr, e_msc;
      for (int k = 0; k < NB; k++) begin
        e_ctl[k*64 +: 64] = m_ctl[k]; e_sts[k*64 +: 64] = m_sts[k];
        e_adr[k*64 +: 64] = m_adr[k]; e_msc[k*64 +: 64] = m_msc[k];
      end
      vectors++;
      cmp("bank_ctl", o_ctl, e_ctl);
      cmp("bank_status", o_sts, e_sts);
      cmp("bank_addr", o_adr, e_adr);
      cmp("bank_misc", o_msc, e_msc);
      cmp("mcg_cap", {{(NB-1)*64{1'b0}}, o_cap}, {{(NB-1)*64{1'b0}}, CAP});
      cmp("mcg_ctl", {{(NB-1)*64{1'b0}}, o_gctl}, {{(NB-1)*64{1'b0}}, m_gctl});
      cmp("mcg_status", {{(NB-1)*64{1'b0}}, o_gsts}, {{(NB-1)*64{1'b0}}, m_gsts});
      cmp("pulses", {{(NB*64-4){1'b0}}, o_acc, o_rej, o_irq, o_shd},
                    {{(NB*64-4){1'b0}}, m_acc, m_rej, m_irq, m_shd});
      // R2: zero capability rejects every request and holds all state
      cmp("R2 nocap pulses", {{(NB*64-4){1'b0}}, z_acc, z_rej, z_irq, z_shd},
                             {{(NB*64-4){1'b0}}, m_zacc, m_zrej, 1'b0, 1'b0});
      cmp("R2 nocap status", z_sts | z_adr | z_msc, '0);
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #2;
      iv = 0; cwe = 0;
    end
  endtask

  task automatic inject(logic [7:0] b, logic [63:0] s, logic [63:0] a, logic [63:0] m,
                        logic [63:0] g, logic u);
    @(posedge clk); #2;
    iv = 1; ib = b; ist = s; iad = a; imi = m; igs = g; iun = u; cwe = 0;
    @(posedge clk); #2;
    iv = 0;
  endtask

  task automatic cfg(logic [1:0] t, logic [7:0] b, logic [63:0] d);
    @(posedge clk); #2;
    cwe = 1; ctg = t; cbk = b; cdt = d; iv = 0;
    @(posedge clk); #2;
    cwe = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R10 watchdog got timeout exp completion");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cr4 = 1; iv = 0; ib = 0; ist = 0; iad = 0; imi = 0; igs = 0; iun = 0;
    cwe = 0; ctg = 0; cbk = 0; cdt = 0;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    idle(2);

    cur_req = "R9";
    cfg(2'd0, 8'd0, ONES);
    cfg(2'd0, 8'd1, ONES);
    cfg(2'd0, 8'd2, ONES);
    cfg(2'd0, 8'd7, ONES);        // out of range bank: ignored
    cfg(2'd1, 8'd0, ONES);
    idle(1);

    cur_req = "R2";
    inject(8'd0, UNC, 64'h11, 64'h22, BSY, 0);        // valid bit clear
    inject(8'd4, VAL, 64'h11, 64'h22, BSY, 0);        // beyond bank count
    inject(8'd200, VAL | UNC, 64'h11, 64'h22, BSY, 0);
    idle(1);

    cur_req = "R8";
    inject(8'd0, VAL | 64'h0A, 64'hA0, 64'hB0, 0, 0); // empty bank: logs
    inject(8'd0, VAL | 64'h0B, 64'hA1, 64'hB1, 0, 0); // valid CE: overwrite + OVR
    idle(1);

    cur_req = "R7";
    inject(8'd1, VAL | UNC | ACT | 64'h33, 64'hC0, 64'hD0, BSY | 64'h1, 0);
    idle(1);

    cur_req = "R3";
    inject(8'd2, VAL | 64'h44, 64'hE0, 64'hF0, 0, 0); // busy, not action: dropped
    inject(8'd2, VAL | 64'h45, 64'hE1, 64'hF1, 0, 1); // forced: logs
    inject(8'd1, VAL | UNC | 64'h46, 64'hE2, 64'hF2, 0, 0); // UC dropped as busy
    idle(1);

    cur_req = "R6";
    inject(8'd1, VAL | UNC | ACT | 64'h55, 64'h1, 64'h2, 0, 0); // busy: shutdown
    idle(1);

    cur_req = "R8";
    inject(8'd1, VAL | ACT | 64'h66, 64'h3, 64'h4, 0, 0); // valid UC: only OVR
    idle(1);

    cur_req = "R9";
    cfg(2'd2, 8'd0, 64'h0);       // clear in-progress
    cfg(2'd3, 8'd2, 64'h0);       // clear bank 2 status
    idle(1);

    cur_req = "R6";
    cr4 = 0;
    inject(8'd0, VAL | UNC | 64'h77, 64'h5, 64'h6, BSY, 0);
    idle(1);
    cr4 = 1;

    cur_req = "R5";
    inject(8'd3, VAL | UNC | 64'h88, 64'h7, 64'h8, BSY, 0);
    idle(1);

    cur_req = "R4";
    cfg(2'd1, 8'd0, 64'hFFFF_FFFF);
    inject(8'd0, VAL | UNC | 64'h99, 64'h9, 64'hA, BSY, 0);
    cfg(2'd1, 8'd0, ONES);
    idle(1);

    cur_req = "R7";
    inject(8'd0, VAL | UNC | 64'hAA, 64'hAB, 64'hAC, BSY, 0); // prior CE: OVR
    idle(1);

    cur_req = "R9";
    @(posedge clk); #2;
    iv = 1; ib = 8'd2; ist = VAL | 64'hBB; iad = 64'hBC; imi = 64'hBD; igs = 0; iun = 1;
    cwe = 1; ctg = 2'd0; cbk = 8'd2; cdt = 64'h0;          // write must be ignored
    @(posedge clk); #2;
    iv = 0; cwe = 0;
    idle(1);

    cur_req = "R10";
    @(posedge clk); #2;
    iv = 1; ib = 8'd3; ist = VAL | 64'hC1; iun = 1;
    @(posedge clk); #2;
    ib = 8'd9;
    @(posedge clk); #2;
    ib = 8'd3; ist = VAL | ACT | 64'hC2;
    @(posedge clk); #2;
    iv = 0;
    idle(2);

    cur_req = "R1";
    @(posedge clk); #2 rst_n = 0;
    idle(2);
    #2 rst_n = 1;
    idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule